// File: doc/BRIEF.md
# DMA Transfer-Size Sequencer

This block plans and issues the memory-bus transactions of one DMA channel. Software sets up a buffer-size code, a direction, a fly-by flag, the source and destination transfer sizes, a peripheral port width, a byte count and two base addresses. A start pulse then launches a run. Before the run begins, the block checks the setup for legality. A setup that fails is refused and flagged.

There are three modes. In a memory-to-memory run, data passes through an internal staging buffer. The buffer holds 64 bytes shifted left by the size code, and the usable transfer size is that buffer size less 32 bytes. One or more source reads fill the buffer, and one destination write then empties it. This repeats until the byte count is used up. In the two fly-by modes, the buffer is bypassed. Each transfer is a single memory transaction, and the peripheral acknowledge strobe is raised while that transaction is in flight. The peripheral either captures the data being read or supplies the data being written.

Each request carries an address, a byte length, a read/write flag and a burst flag. A request is held until it is accepted, and the next one waits for a completion pulse. Bus arbitration, data storage and descriptor handling are outside this block.

Top module: `dma_size_seq`

## Requirements
- R1: During and right after reset, `req_valid`, `dack`, `busy`, `done` and `config_error` are all low.
- R2: Size codes 0 to 4 give a buffer of 64, 128, 256, 512 or 1024 bytes. In memory-to-memory mode, `dst_size` must equal that buffer size minus 32 (32, 96, 224, 480, 992). Size codes 5 to 7 are refused.
- R3: The mode is decoded from `dir_code` and `flyby`. 00 with `flyby`=0 is memory-to-memory, 01 with `flyby`=1 is memory-to-peripheral, and 10 with `flyby`=1 is peripheral-to-memory. Every other combination is refused.
- R4: In memory-to-memory mode, `src_size` must be a nonzero multiple of 32 whose count of 32-byte units divides the maximum unit count. The buffer is then filled by (dst_size / src_size) reads; for example, a 480-byte buffer takes 1, 3, 5 or 15 reads for sources of 480, 160, 96 or 32 bytes.
- R5: Each memory-to-memory round issues its fill reads first and then one write of `dst_size` bytes. The reads start at `src_base` and step by `src_size`. The writes start at `dst_base` and step by `dst_size`. Rounds repeat until the byte count is exhausted.
- R6: In fly-by modes, the memory-side size (`dst_size` for memory-to-peripheral, `src_size` for peripheral-to-memory) must equal `port_size` or 32, and `port_size` must be 1, 2, 4 or 8. Each transfer is one request: a read at the advancing source address, or a write at the advancing destination address.
- R7: `req_burst` is high exactly when `req_bytes` is a multiple of 32; smaller requests are single beats.
- R8: `dack` is high from the cycle after a fly-by request is accepted up to and including the cycle its `req_done` arrives. It is never high in memory-to-memory mode.
- R9: `byte_count` must be a nonzero multiple of the memory-side transfer size. Each completed destination-side (or fly-by) transfer reduces the remainder. After the final completion, `done` is high for exactly one cycle and `busy` is low.
- R10: A start with an illegal setup sets `config_error`, issues no request and leaves `busy` low. The next start with a legal setup clears `config_error`.
- R11: A start pulse while a run is in progress is ignored. The running transfer keeps the setup it latched at its own start, even if the setup inputs change.
- R12: `req_valid` stays high with address, length and direction unchanged until `req_ready` is seen. No new request is raised before the accepted one's `req_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a run |
| wrap_code | input | 3 | Staging-buffer size code |
| dir_code | input | 2 | Transfer direction code |
| flyby | input | 1 | Fly-by flag |
| src_size | input | SW | Source transfer size in bytes |
| dst_size | input | SW | Destination transfer size in bytes |
| port_size | input | SW | Peripheral port width in bytes |
| byte_count | input | CW | Total bytes to move |
| src_base | input | AW | First source address |
| dst_base | input | AW | First destination address |
| req_ready | input | 1 | Bus accepts the pending request |
| req_done | input | 1 | Accepted request has completed |
| req_valid | output | 1 | Request pending |
| req_addr | output | AW | Request address |
| req_bytes | output | SW | Request length in bytes |
| req_burst | output | 1 | Request is made of 32-byte bursts |
| req_write | output | 1 | Request is a write |
| dack | output | 1 | Peripheral acknowledge strobe |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| config_error | output | 1 | Last start was refused |

## Verification
The bench focuses on the fill count at the odd divisors of the 480-byte buffer (3 and 5 reads) and at the 31-read extreme. A design that derived the read count from a power of two, or that wrote after each read, would produce a request list of the wrong length or order. Each illegal setup is tried on its own: a wrong destination size, an out-of-range size code, a bad direction pair, a non-dividing source, a mismatched fly-by size and a ragged byte count. A block that skipped any one of these checks would emit requests instead of raising the error. The bench also counts the cycles `dack` is high per fly-by transfer to catch an off-by-one window. It fires a second start mid-run with a changed setup to expose a sequencer that re-reads live inputs. Finally, it holds `req_ready` low to catch a request whose fields drift before acceptance.

// File: rtl/dmaseq_pkg.sv
`timescale 1ns/1ps
package dmaseq_pkg;
  localparam int UNIT_B   = 32;
  localparam int WRAP_TOP = 4;

  typedef enum logic [1:0] {MODE_M2M, MODE_M2P, MODE_P2M, MODE_BAD} mode_e;
  typedef enum logic [1:0] {PH_FILL, PH_DRAIN, PH_FLY} phase_e;

  // staging buffer size in bytes for a size code
  function automatic int buf_bytes(input int wrap);
    return (2 * UNIT_B) << wrap;
  endfunction

  // usable transfer size: one unit less than the buffer
  function automatic int max_bytes(input int wrap);
    return buf_bytes(wrap) - UNIT_B;
  endfunction

  function automatic int max_units(input int wrap);
    return max_bytes(wrap) / UNIT_B;
  endfunction

  function automatic bit port_ok(input int p);
    return (p == 1) || (p == 2) || (p == 4) || (p == 8);
  endfunction

  function automatic bit fly_size_ok(input int sz, input int p);
    return port_ok(p) && ((sz == p) || (sz == UNIT_B));
  endfunction

  function automatic bit src_ok(input int wrap, input int src);
    if (src <= 0 || (src % UNIT_B) != 0) return 1'b0;
    return (max_units(wrap) % (src / UNIT_B)) == 0;
  endfunction

  function automatic int fill_reads(input int wrap, input int src);
    return max_units(wrap) / (src / UNIT_B);
  endfunction

  function automatic mode_e decode_mode(input logic [1:0] d, input logic f);
    if (d == 2'b00 && !f) return MODE_M2M;
    if (d == 2'b01 && f)  return MODE_M2P;
    if (d == 2'b10 && f)  return MODE_P2M;
    return MODE_BAD;
  endfunction
endpackage

// File: rtl/dmaseq_cfg_check.sv
`timescale 1ns/1ps
module dmaseq_cfg_check
  import dmaseq_pkg::*;
#(
  parameter int SW = 11,
  parameter int CW = 16,
  parameter int RW = 6
) (
  input  logic [2:0]    wrap_code,
  input  logic [1:0]    dir_code,
  input  logic          flyby,
  input  logic [SW-1:0] src_size,
  input  logic [SW-1:0] dst_size,
  input  logic [SW-1:0] port_size,
  input  logic [CW-1:0] byte_count,
  output logic          cfg_ok,
  output mode_e         mode,
  output logic [RW-1:0] n_reads,
  output logic [SW-1:0] step_bytes
);
  int   w, s, d, p, c, step, reads;
  logic ok;

  always_comb begin
    w     = int'(wrap_code);
    s     = int'(src_size);
    d     = int'(dst_size);
    p     = int'(port_size);
    c     = int'(byte_count);
    mode  = decode_mode(dir_code, flyby);
    ok    = (w <= WRAP_TOP);
    reads = 1;
    step  = 0;
    case (mode)
      MODE_M2M: begin
        step = d;
        if (d != max_bytes(w)) ok = 1'b0;
        if (!src_ok(w, s)) ok = 1'b0;
        else reads = fill_reads(w, s);
      end
      MODE_M2P: begin
        step = d;
        if (!fly_size_ok(d, p)) ok = 1'b0;
      end
      MODE_P2M: begin
        step = s;
        if (!fly_size_ok(s, p)) ok = 1'b0;
      end
      default: ok = 1'b0;
    endcase
    if (c == 0 || step == 0) ok = 1'b0;
    else if ((c % step) != 0) ok = 1'b0;
    cfg_ok     = ok;
    n_reads    = RW'(reads);
    step_bytes = SW'(step);
  end
endmodule

// File: rtl/dmaseq_track.sv
`timescale 1ns/1ps
module dmaseq_track #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] byte_count,
  input  logic [SW-1:0] src_size,
  input  logic [SW-1:0] dst_size,
  input  logic [SW-1:0] step_in,
  input  logic          fly_in,
  input  logic          adv_src,
  input  logic          adv_dst,
  input  logic          dec,
  output logic [AW-1:0] src_cur,
  output logic [AW-1:0] dst_cur,
  output logic [CW-1:0] remain,
  output logic [SW-1:0] src_l,
  output logic [SW-1:0] dst_l,
  output logic [SW-1:0] step_l,
  output logic          last
);
  logic          fly_l;
  logic [SW-1:0] src_inc, dst_inc;

  assign src_inc = fly_l ? step_l : src_l;
  assign dst_inc = fly_l ? step_l : dst_l;
  assign last    = (remain == CW'(step_l));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_cur <= '0;
      dst_cur <= '0;
      remain  <= '0;
      src_l   <= '0;
      dst_l   <= '0;
      step_l  <= '0;
      fly_l   <= 1'b0;
    end else if (load) begin
      src_cur <= src_base;
      dst_cur <= dst_base;
      remain  <= byte_count;
      src_l   <= src_size;
      dst_l   <= dst_size;
      step_l  <= step_in;
      fly_l   <= fly_in;
    end else begin
      if (adv_src) src_cur <= src_cur + AW'(src_inc);
      if (adv_dst) dst_cur <= dst_cur + AW'(dst_inc);
      if (dec)     remain  <= remain - CW'(step_l);
    end
  end

  // R9: the remainder never wraps below zero
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (remain >= CW'(step_l)));
endmodule

// File: rtl/dmaseq_fsm.sv
`timescale 1ns/1ps
module dmaseq_fsm
  import dmaseq_pkg::*;
#(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_ok,
  input  mode_e         mode_in,
  input  logic [RW-1:0] n_reads,
  input  logic          req_ready,
  input  logic          req_done,
  input  logic          last,
  output logic          load,
  output logic          adv_src,
  output logic          adv_dst,
  output logic          dec,
  output logic          req_valid,
  output logic          req_write,
  output logic          req_from_dst,
  output phase_e        phase,
  output logic          dack,
  output logic          busy,
  output logic          done,
  output logic          config_error
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e           st;
  mode_e         mode_l;
  logic [RW-1:0] rd_left, reads_l;
  logic          step_evt, fly_wr;

  assign load      = (st == ST_IDLE) && start && cfg_ok;
  assign step_evt  = (st == ST_WAIT) && req_done;
  assign req_valid = (st == ST_ISSUE);
  assign busy      = (st != ST_IDLE);
  assign dack      = (st == ST_WAIT) && (phase == PH_FLY);
  assign fly_wr    = (phase == PH_FLY) && (mode_l == MODE_P2M);
  assign req_write    = (phase == PH_DRAIN) || fly_wr;
  assign req_from_dst = req_write;
  assign adv_src   = step_evt && ((phase == PH_FILL) || ((phase == PH_FLY) && (mode_l == MODE_M2P)));
  assign adv_dst   = step_evt && ((phase == PH_DRAIN) || fly_wr);
  assign dec       = step_evt && (phase != PH_FILL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      phase        <= PH_FILL;
      mode_l       <= MODE_M2M;
      rd_left      <= '0;
      reads_l      <= '0;
      done         <= 1'b0;
      config_error <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (cfg_ok) begin
              config_error <= 1'b0;
              mode_l       <= mode_in;
              phase        <= (mode_in == MODE_M2M) ? PH_FILL : PH_FLY;
              rd_left      <= n_reads;
              reads_l      <= n_reads;
              st           <= ST_ISSUE;
            end else begin
              config_error <= 1'b1;
            end
          end
        end
        ST_ISSUE: if (req_ready) st <= ST_WAIT;
        ST_WAIT: begin
          if (req_done) begin
            case (phase)
              PH_FILL: begin
                if (rd_left == RW'(1)) phase <= PH_DRAIN;
                rd_left <= rd_left - RW'(1);
                st      <= ST_ISSUE;
              end
              PH_DRAIN: begin
                if (last) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
                end else begin
                  phase   <= PH_FILL;
                  rd_left <= reads_l;
                  st      <= ST_ISSUE;
                end
              end
              default: begin
                if (last) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
                end else begin
                  st <= ST_ISSUE;
                end
              end
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: the strobe belongs to fly-by runs only
  a_r8_dack_only_flyby: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (mode_l != MODE_M2M));
  // R12: an unaccepted request stays up
  a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);
  // R9: end-of-run pulse lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: a refused start never leaves the engine running
  a_r10_refuse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(config_error) |-> !busy);
  // R4: the drain write follows only a completed fill
  a_r4_fill_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && phase == PH_DRAIN) |-> (rd_left == '0));
endmodule

// File: rtl/dma_size_seq.sv
`timescale 1ns/1ps
module dma_size_seq
  import dmaseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    wrap_code,
  input  logic [1:0]    dir_code,
  input  logic          flyby,
  input  logic [SW-1:0] src_size,
  input  logic [SW-1:0] dst_size,
  input  logic [SW-1:0] port_size,
  input  logic [CW-1:0] byte_count,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic          req_ready,
  input  logic          req_done,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [SW-1:0] req_bytes,
  output logic          req_burst,
  output logic          req_write,
  output logic          dack,
  output logic          busy,
  output logic          done,
  output logic          config_error
);
  localparam int RW     = $clog2(max_units(WRAP_TOP) + 1) + 1;
  localparam int UB_LOG = $clog2(UNIT_B);

  logic          cfg_ok, load, adv_src, adv_dst, dec, last, from_dst;
  mode_e         mode;
  phase_e        phase;
  logic [RW-1:0] n_reads;
  logic [SW-1:0] step_bytes, src_l, dst_l, step_l;
  logic [AW-1:0] src_cur, dst_cur;
  logic [CW-1:0] remain;

  dmaseq_cfg_check #(.SW(SW), .CW(CW), .RW(RW)) u_check (
    .wrap_code(wrap_code), .dir_code(dir_code), .flyby(flyby),
    .src_size(src_size), .dst_size(dst_size), .port_size(port_size),
    .byte_count(byte_count), .cfg_ok(cfg_ok), .mode(mode),
    .n_reads(n_reads), .step_bytes(step_bytes)
  );

  dmaseq_fsm #(.RW(RW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_ok(cfg_ok),
    .mode_in(mode), .n_reads(n_reads), .req_ready(req_ready),
    .req_done(req_done), .last(last), .load(load), .adv_src(adv_src),
    .adv_dst(adv_dst), .dec(dec), .req_valid(req_valid),
    .req_write(req_write), .req_from_dst(from_dst), .phase(phase),
    .dack(dack), .busy(busy), .done(done), .config_error(config_error)
  );

  dmaseq_track #(.AW(AW), .CW(CW), .SW(SW)) u_track (
    .clk(clk), .rst_n(rst_n), .load(load), .src_base(src_base),
    .dst_base(dst_base), .byte_count(byte_count), .src_size(src_size),
    .dst_size(dst_size), .step_in(step_bytes), .fly_in(mode != MODE_M2M),
    .adv_src(adv_src), .adv_dst(adv_dst), .dec(dec), .src_cur(src_cur),
    .dst_cur(dst_cur), .remain(remain), .src_l(src_l), .dst_l(dst_l),
    .step_l(step_l), .last(last)
  );

  assign req_addr = from_dst ? dst_cur : src_cur;

  always_comb begin
    case (phase)
      PH_FILL:  req_bytes = src_l;
      PH_DRAIN: req_bytes = dst_l;
      default:  req_bytes = step_l;
    endcase
  end

  assign req_burst = req_valid && (req_bytes[UB_LOG-1:0] == '0);

  // R12: request fields hold until accepted
  a_r12_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ($stable(req_addr) && $stable(req_bytes) && $stable(req_write)));
  // R9: the end pulse comes with nothing left to move
  a_r9_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remain == '0));
  // R7: a burst request always spans at least one full unit
  a_r7_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_burst) |-> (int'(req_bytes) >= UNIT_B));
  // R8: strobe and pending request never overlap
  a_r8_dack_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> !req_valid);
endmodule

// File: tb/test_dma_size_seq.sv
`timescale 1ns/1ps
module test_dma_size_seq;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int SW = 11;
  localparam int LOGN = 128;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] wrap_code = '0;
  logic [1:0] dir_code = '0;
  logic flyby = 1'b0;
  logic [SW-1:0] src_size = '0, dst_size = '0, port_size = '0;
  logic [CW-1:0] byte_count = '0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic req_ready = 1'b0, req_done = 1'b0;
  logic req_valid, req_burst, req_write, dack, busy, done, config_error;
  logic [AW-1:0] req_addr;
  logic [SW-1:0] req_bytes;

  always #10 clk = ~clk;

  dma_size_seq #(.AW(AW), .CW(CW), .SW(SW)) i_dma_size_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wrap_code(wrap_code),
    .dir_code(dir_code), .flyby(flyby), .src_size(src_size),
    .dst_size(dst_size), .port_size(port_size), .byte_count(byte_count),
    .src_base(src_base), .dst_base(dst_base), .req_ready(req_ready),
    .req_done(req_done), .req_valid(req_valid), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_burst(req_burst), .req_write(req_write),
    .dack(dack), .busy(busy), .done(done), .config_error(config_error)
  );

  int checks = 0, errors = 0;
  int lat = 2, rdy_dly = 0;
  int n_log = 0, dack_cyc = 0, hold_bad = 0, overlap_bad = 0;
  logic [AW-1:0] log_addr [LOGN];
  int  log_bytes [LOGN];
  bit  log_wr [LOGN];
  bit  log_burst [LOGN];
  int  n_exp = 0;
  logic [AW-1:0] e_addr [LOGN];
  int  e_bytes [LOGN];
  bit  e_wr [LOGN];
  logic [AW-1:0] cap_addr;
  int  cap_bytes;
  logic cap_wr;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bus responder: optional accept delay, fixed completion latency
  always begin
    @(negedge clk);
    if (req_valid) begin
      cap_addr = req_addr; cap_bytes = int'(req_bytes); cap_wr = req_write;
      for (int k = 0; k < rdy_dly; k++) begin
        @(negedge clk);
        if (!req_valid || req_addr !== cap_addr || int'(req_bytes) != cap_bytes || req_write !== cap_wr)
          hold_bad++;
      end
      if (n_log < LOGN) begin
        log_addr[n_log] = req_addr; log_bytes[n_log] = int'(req_bytes);
        log_wr[n_log] = req_write; log_burst[n_log] = req_burst;
      end
      n_log++;
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      for (int k = 0; k < lat; k++) begin
        if (req_valid) overlap_bad++;
        @(negedge clk);
      end
      if (req_valid) overlap_bad++;
      req_done = 1'b1;
      @(negedge clk);
      req_done = 1'b0;
    end
  end

  always @(negedge clk) if (dack) dack_cyc++;

  task automatic push(input logic [AW-1:0] a, input int b, input bit w);
    if (n_exp < LOGN) begin e_addr[n_exp] = a; e_bytes[n_exp] = b; e_wr[n_exp] = w; end
    n_exp++;
  endtask

  task automatic exp_m2m(input int wrap, input int src, input int dst, input int cnt,
                         input logic [AW-1:0] sb, input logic [AW-1:0] db);
    int units = ((64 << wrap) / 32) - 1;
    int reads = units / (src / 32);
    logic [AW-1:0] sa = sb, da = db;
    n_exp = 0;
    for (int r = 0; r < cnt / dst; r++) begin
      for (int k = 0; k < reads; k++) begin push(sa, src, 1'b0); sa = sa + AW'(src); end
      push(da, dst, 1'b1); da = da + AW'(dst);
    end
  endtask

  task automatic exp_fly(input bit p2m, input int sz, input int cnt,
                         input logic [AW-1:0] sb, input logic [AW-1:0] db);
    n_exp = 0;
    for (int i = 0; i < cnt / sz; i++)
      if (p2m) push(db + AW'(i * sz), sz, 1'b1);
      else     push(sb + AW'(i * sz), sz, 1'b0);
  endtask

  task automatic set_cfg(input int wrap, input int dir, input int fly, input int src,
                         input int dst, input int port, input int cnt,
                         input logic [AW-1:0] sb, input logic [AW-1:0] db);
    wrap_code = 3'(wrap); dir_code = 2'(dir); flyby = (fly != 0);
    src_size = SW'(src); dst_size = SW'(dst); port_size = SW'(port);
    byte_count = CW'(cnt); src_base = sb; dst_base = db;
  endtask

  task automatic clear_log();
    n_log = 0; dack_cyc = 0; hold_bad = 0; overlap_bad = 0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string nm);
    int guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    chk("R9", {nm, " done pulse seen"}, int'(done), 1);
    chk("R9", {nm, " busy low with done"}, int'(busy), 0);
    @(negedge clk);
    chk("R9", {nm, " done lasts one cycle"}, int'(done), 0);
  endtask

  task automatic compare(input string nm, input string req);
    int mism = 0, bmis = 0;
    chk(req, {nm, " request count"}, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log && i < LOGN; i++) begin
      if (log_addr[i] !== e_addr[i] || log_bytes[i] != e_bytes[i] || log_wr[i] != e_wr[i]) begin
        if (mism == 0)
          $display("  %s first diff at %0d: addr=%h bytes=%0d wr=%0d vs addr=%h bytes=%0d wr=%0d",
                   nm, i, log_addr[i], log_bytes[i], log_wr[i], e_addr[i], e_bytes[i], e_wr[i]);
        mism++;
      end
      if (log_burst[i] != ((log_bytes[i] % 32) == 0)) bmis++;
    end
    chk(req, {nm, " request mismatches"}, mism, 0);
    chk("R7", {nm, " burst flag mismatches"}, bmis, 0);
    chk("R12", {nm, " request overlaps"}, overlap_bad, 0);
  endtask

  task automatic t_reset();
    chk("R1", "req_valid in reset", int'(req_valid), 0);
    chk("R1", "dack in reset", int'(dack), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "config_error in reset", int'(config_error), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", int'(done), 0);
  endtask

  task automatic run_m2m(input string nm, input string req, input int wrap, input int src,
                         input int cnt);
    int dst = ((64 << wrap) / 32 - 1) * 32;
    set_cfg(wrap, 0, 0, src, dst, 1, cnt, 32'h1000_0000, 32'h2000_0000);
    exp_m2m(wrap, src, dst, cnt, 32'h1000_0000, 32'h2000_0000);
    clear_log();
    pulse_start();
    wait_done(nm);
    compare(nm, req);
    chk("R8", {nm, " dack cycles"}, dack_cyc, 0);
  endtask

  task automatic run_fly(input string nm, input bit p2m, input int sz, input int port,
                         input int cnt);
    if (p2m) set_cfg(1, 2, 1, sz, 0, port, cnt, 32'h0000_0040, 32'h3000_0100);
    else     set_cfg(1, 1, 1, 0, sz, port, cnt, 32'h0000_0040, 32'h3000_0100);
    exp_fly(p2m, sz, cnt, 32'h0000_0040, 32'h3000_0100);
    clear_log();
    pulse_start();
    wait_done(nm);
    compare(nm, "R6");
    chk("R8", {nm, " dack cycles"}, dack_cyc, n_exp * (lat + 1));
  endtask

  task automatic run_bad(input string nm, input string req, input int wrap, input int dir,
                         input int fly, input int src, input int dst, input int port,
                         input int cnt);
    set_cfg(wrap, dir, fly, src, dst, port, cnt, 32'h10, 32'h20);
    clear_log();
    pulse_start();
    chk(req, {nm, " config_error raised"}, int'(config_error), 1);
    chk("R10", {nm, " busy stays low"}, int'(busy), 0);
    repeat (4) @(negedge clk);
    chk("R10", {nm, " no request issued"}, n_log, 0);
  endtask

  task automatic t_busy_start();
    set_cfg(1, 1, 1, 0, 4, 4, 16, 32'h0000_0400, 32'h0);
    exp_fly(1'b0, 4, 16, 32'h0000_0400, 32'h0);
    clear_log();
    pulse_start();
    repeat (4) @(negedge clk);
    set_cfg(2, 2, 1, 32, 0, 8, 64, 32'h0000_9000, 32'h0000_a000);
    pulse_start();
    wait_done("restart while busy");
    compare("restart while busy", "R11");
    chk("R11", "config_error untouched", int'(config_error), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    run_m2m("m2m 64B buffer", "R2", 0, 32, 64);
    run_m2m("m2m three reads", "R4", 3, 160, 960);
    rdy_dly = 2;
    run_m2m("m2m five reads held", "R5", 3, 96, 480);
    chk("R12", "fields held while not ready", hold_bad, 0);
    rdy_dly = 0;
    run_m2m("m2m 31 reads", "R5", 4, 32, 992);
    run_fly("mem to periph single", 1'b0, 4, 4, 16);
    lat = 1;
    run_fly("periph to mem burst", 1'b1, 32, 8, 64);
    lat = 2;
    run_bad("bad dst size", "R2", 3, 0, 0, 160, 224, 1, 224);
    run_bad("bad wrap code", "R2", 5, 0, 0, 32, 2016, 1, 2016);
    run_bad("bad dir pair", "R3", 0, 1, 0, 32, 32, 4, 64);
    run_bad("bad dir code", "R3", 0, 3, 1, 32, 32, 4, 64);
    run_bad("non dividing src", "R4", 3, 0, 0, 64, 480, 1, 480);
    run_bad("fly size mismatch", "R6", 1, 1, 1, 0, 16, 4, 64);
    run_bad("odd port width", "R6", 1, 2, 1, 3, 0, 3, 9);
    run_bad("ragged count", "R9", 0, 0, 0, 32, 32, 1, 100);
    run_bad("zero count", "R9", 0, 0, 0, 32, 32, 1, 0);
    run_m2m("legal after error", "R10", 1, 32, 96);
    chk("R10", "config_error cleared", int'(config_error), 0);
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule